// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Write Buffer

This block is a small direct-mapped data cache for a 32-bit little-endian core. It holds 256 lines, and each line is a single 32-bit word, for 1 KB of data in total. Both the index and the tag are taken from the physical address. The core issues word, half-word and byte loads and stores. The block aligns store data onto byte lanes, generates the byte enables, and returns load data right-justified, either zero- or sign-extended.

Every store goes through to main memory. A posted FIFO of four entries captures each store's word address, byte enables and data in the cycle the core issues it. It then retires the stores to a slow request/acknowledge memory port one at a time. A store that hits the cache also merges its enabled bytes into the cached word. A store that misses does not allocate a line.

A load miss stalls the core. The block waits until no buffered write to the same word address remains, reads one word, and installs the tag, data and valid bit. The core keeps its request asserted, and the request then completes as a hit.

Top module: `wt_dcache`

## Requirements
- R1: Reset clears every valid bit and empties the write buffer. After reset `mem_req` is low, no buffered store reaches memory, and a load to a previously cached address misses.
- R2: A load that hits is acknowledged in the cycle it is requested, with its data on `cpu_rdata`. It issues no memory read.
- R3: A load that misses is not acknowledged until a single memory read (`mem_we`=0, `mem_be`=4'b1111, word-aligned address) has completed. The returned word is installed, the held request is then acknowledged with that data, and later loads to the word hit.
- R4: A store is acknowledged in the cycle it is requested whenever fewer than 4 stores are pending. While 4 are pending it is held off until an entry retires.
- R5: Every accepted store reaches memory as one write carrying its word address, its byte enables and its data placed on those byte lanes.
- R6: A store that hits changes only its enabled bytes of the cached word. A store that misses leaves the cache unchanged, so a following load to that word misses.
- R7: Buffered stores are written to memory in the order they were accepted, with one entry retired per memory acknowledge.
- R8: A load miss does not start its memory read while a buffered store to the same word address is pending, so it returns the stored data.
- R9: Byte order is little-endian. A byte access uses lane `addr[1:0]` and a half-word access uses lane `addr[1]`, where `cpu_size` is 0 for a byte, 1 for a half-word and 2 or 3 for a word. With `cpu_sext`=1 a loaded byte or half-word is sign-extended; otherwise it is zero-extended.
- R10: Once raised, `mem_req` stays high with a stable address, direction, byte enables and data until the cycle of `mem_ack`.
- R11: The line index is `addr[9:2]` and the tag is `addr[31:10]`. Two addresses with equal index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Core access request, held until acknowledged |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_size | input | 2 | Access size: 0 byte, 1 half-word, 2/3 word |
| cpu_sext | input | 1 | Sign-extend a byte or half-word load |
| cpu_addr | input | 32 | Physical byte address |
| cpu_wdata | input | 32 | Store data, right-justified |
| cpu_ack | output | 1 | Access completes at the end of this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` on a load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a buffered write, 0 for a refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables of the transfer |
| mem_wdata | output | 32 | Write data on its byte lanes |
| mem_ack | input | 1 | Transfer completes at the end of this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Load hits and accepted stores show `cpu_ack` in the request cycle itself. The bench therefore drives each request just after a falling edge and samples the acknowledge and data one nanosecond later, before the rising edge that completes the access. On a load miss the state change and the memory grant each add a register, so `mem_req` rises two edges after the request, and the acknowledge comes one cycle after the edge that captures `mem_ack`. The bench counts the falling edges it waits for an acknowledge: zero means a hit, and any other count means a miss, which must match its own tag model. The memory model raises `mem_ack` at a falling edge after a programmable wait, so the design sees it at the next rising edge. Drain order and contents are compared only after a wait longer than four full write latencies.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

   // Access size code on the core port (2'b11 behaves as a word)
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_size_e;

   // Core-side control state
   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_MISS = 1'b1
   } ctl_state_e;

endpackage

// File: rtl/wt_dcache_lane.sv
module wt_dcache_lane
   import wt_dcache_pkg::*;
(
   input  logic [1:0]  size,
   input  logic        sext,
   input  logic [1:0]  lo,
   input  logic [31:0] st_data,
   input  logic [31:0] line_word,
   output logic [3:0]  st_be,
   output logic [31:0] st_lanes,
   output logic [31:0] ld_data
);

   logic [31:0] byte_sh;
   logic [31:0] half_sh;

   // little-endian: byte lane n occupies bits 8n+7..8n
   assign byte_sh = line_word >> {lo, 3'b000};
   assign half_sh = line_word >> {lo[1], 4'b0000};

   always_comb begin
      case (acc_size_e'(size))
         SZ_BYTE: begin
            st_be    = 4'b0001 << lo;
            st_lanes = {4{st_data[7:0]}};
            ld_data  = {{24{sext & byte_sh[7]}}, byte_sh[7:0]};
         end
         SZ_HALF: begin
            st_be    = lo[1] ? 4'b1100 : 4'b0011;
            st_lanes = {2{st_data[15:0]}};
            ld_data  = {{16{sext & half_sh[15]}}, half_sh[15:0]};
         end
         default: begin
            st_be    = 4'b1111;
            st_lanes = st_data;
            ld_data  = line_word;
         end
      endcase
   end

endmodule

// File: rtl/wt_dcache_array.sv
module wt_dcache_array #(
   parameter int LINES  = 256,
   parameter int TAG_W  = 22,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(LINES)-1:0] rd_idx,
   output logic                     rd_valid,
   output logic [TAG_W-1:0]         rd_tag,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     wr_en,
   input  logic                     wr_fill,
   input  logic [$clog2(LINES)-1:0] wr_idx,
   input  logic [TAG_W-1:0]         wr_tag,
   input  logic [DATA_W/8-1:0]      wr_be,
   input  logic [DATA_W-1:0]        wr_data
);

   localparam int NB    = DATA_W / 8;
   localparam int IDX_W = $clog2(LINES);

   if ((LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("wt_dcache_array: LINES must be a power of two");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("wt_dcache_array: DATA_W must be a whole number of bytes");
   end

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   // only valid bits are reset; tags and data are qualified by them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en && wr_fill) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_fill) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   // one storage bank per byte lane so partial stores need no read-modify-write
   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [7:0] bank_q [LINES];

      always_ff @(posedge clk) begin
         if (wr_en && wr_be[b]) begin
            bank_q[wr_idx] <= wr_data[8*b +: 8];
         end
      end

      assign rd_data[8*b +: 8] = bank_q[rd_idx];
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   // a line fill always writes the whole word
   AST_FILL_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_fill) |-> (wr_be == {NB{1'b1}}))                     // R3
      else $error("fill with partial byte enables");

   AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_fill) |=> valid_q[$past(wr_idx)])                    // R3
      else $error("filled line not valid");

   if (IDX_W < 1) begin : g_bad_idx
      $error("wt_dcache_array: need at least two lines");
   end

endmodule

// File: rtl/wt_dcache_wbuf.sv
module wt_dcache_wbuf #(
   parameter int DEPTH   = 4,
   parameter int WADDR_W = 30,
   parameter int DATA_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  logic [WADDR_W-1:0]   push_waddr,
   input  logic [DATA_W/8-1:0]  push_be,
   input  logic [DATA_W-1:0]    push_data,
   input  logic                 pop,
   output logic [WADDR_W-1:0]   head_waddr,
   output logic [DATA_W/8-1:0]  head_be,
   output logic [DATA_W-1:0]    head_data,
   output logic                 full,
   output logic                 empty,
   input  logic [WADDR_W-1:0]   probe_waddr,
   output logic                 probe_hit
);

   localparam int NB = DATA_W / 8;
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wt_dcache_wbuf: DEPTH must be a power of two, at least 2");
   end

   logic [WADDR_W-1:0] addr_q [DEPTH];
   logic [NB-1:0]      be_q   [DEPTH];
   logic [DATA_W-1:0]  data_q [DEPTH];
   logic [DEPTH-1:0]   occ_q;
   logic [PW-1:0]      wr_ptr_q;
   logic [PW-1:0]      rd_ptr_q;
   logic [DEPTH-1:0]   slot_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q    <= '0;
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
      end else begin
         if (pop) begin
            occ_q[rd_ptr_q] <= 1'b0;
            rd_ptr_q        <= rd_ptr_q + 1'b1;
         end
         if (push) begin
            occ_q[wr_ptr_q] <= 1'b1;
            wr_ptr_q        <= wr_ptr_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr_q] <= push_waddr;
         be_q[wr_ptr_q]   <= push_be;
         data_q[wr_ptr_q] <= push_data;
      end
   end

   // per-entry address comparators for the load-after-store check
   for (genvar i = 0; i < DEPTH; i++) begin : g_probe
      assign slot_match[i] = occ_q[i] && (addr_q[i] == probe_waddr);
   end

   assign probe_hit  = |slot_match;
   assign full       = &occ_q;
   assign empty      = ~|occ_q;
   assign head_waddr = addr_q[rd_ptr_q];
   assign head_be    = be_q[rd_ptr_q];
   assign head_data  = data_q[rd_ptr_q];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full))                                                  // R4
      else $error("push into a full write buffer");

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty))                                                  // R7
      else $error("pop from an empty write buffer");

   AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop && !empty) |=> ($stable(head_waddr) && $stable(head_data)))  // R7
      else $error("buffer head moved without a retire");

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
   import wt_dcache_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int LINES    = 256,
   parameter int WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic              cpu_sext,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata
);

   localparam int NB      = DATA_W / 8;
   localparam int OFF_W   = $clog2(NB);
   localparam int IDX_W   = $clog2(LINES);
   localparam int WADDR_W = ADDR_W - OFF_W;
   localparam int TAG_W   = WADDR_W - IDX_W;

   if (DATA_W != 32) begin : g_bad_data
      $error("wt_dcache: lane logic is built for 32-bit words");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("wt_dcache: LINES must be a power of two");
   end
   if (WB_DEPTH < 2 || (WB_DEPTH & (WB_DEPTH - 1)) != 0) begin : g_bad_wb
      $error("wt_dcache: WB_DEPTH must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wt_dcache: address too narrow for the index");
   end

   // request decode
   logic [WADDR_W-1:0] req_waddr;
   logic [IDX_W-1:0]   req_idx;
   logic [TAG_W-1:0]   req_tag;

   assign req_waddr = cpu_addr[ADDR_W-1:OFF_W];
   assign req_idx   = req_waddr[IDX_W-1:0];
   assign req_tag   = req_waddr[WADDR_W-1:IDX_W];

   // state
   ctl_state_e         st_q;
   logic [WADDR_W-1:0] miss_waddr_q;
   logic               busy_q;
   logic               rd_q;

   // array signals
   logic               line_valid;
   logic [TAG_W-1:0]   line_tag;
   logic [DATA_W-1:0]  line_data;
   logic               arr_wr_en;
   logic               arr_fill;
   logic [IDX_W-1:0]   arr_wr_idx;
   logic [NB-1:0]      arr_wr_be;
   logic [DATA_W-1:0]  arr_wr_data;

   // lane signals
   logic [NB-1:0]      st_be;
   logic [DATA_W-1:0]  st_lanes;
   logic [DATA_W-1:0]  ld_data;

   // buffer signals
   logic               wb_push;
   logic               wb_pop;
   logic               wb_full;
   logic               wb_empty;
   logic               wb_hazard;
   logic [WADDR_W-1:0] wb_head_waddr;
   logic [NB-1:0]      wb_head_be;
   logic [DATA_W-1:0]  wb_head_data;

   logic hit;
   logic running;
   logic ld_ack;
   logic st_ack;
   logic miss_start;
   logic grant_rd;
   logic grant_wr;

   wt_dcache_array #(
      .LINES  (LINES),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (req_idx),
      .rd_valid (line_valid),
      .rd_tag   (line_tag),
      .rd_data  (line_data),
      .wr_en    (arr_wr_en),
      .wr_fill  (arr_fill),
      .wr_idx   (arr_wr_idx),
      .wr_tag   (miss_waddr_q[WADDR_W-1:IDX_W]),
      .wr_be    (arr_wr_be),
      .wr_data  (arr_wr_data)
   );

   wt_dcache_lane u_lane (
      .size      (cpu_size),
      .sext      (cpu_sext),
      .lo        (cpu_addr[1:0]),
      .st_data   (cpu_wdata),
      .line_word (line_data),
      .st_be     (st_be),
      .st_lanes  (st_lanes),
      .ld_data   (ld_data)
   );

   wt_dcache_wbuf #(
      .DEPTH   (WB_DEPTH),
      .WADDR_W (WADDR_W),
      .DATA_W  (DATA_W)
   ) u_wbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (wb_push),
      .push_waddr  (req_waddr),
      .push_be     (st_be),
      .push_data   (st_lanes),
      .pop         (wb_pop),
      .head_waddr  (wb_head_waddr),
      .head_be     (wb_head_be),
      .head_data   (wb_head_data),
      .full        (wb_full),
      .empty       (wb_empty),
      .probe_waddr (miss_waddr_q),
      .probe_hit   (wb_hazard)
   );

   // core side
   assign hit        = line_valid && (line_tag == req_tag);
   assign running    = (st_q == ST_RUN);
   assign ld_ack     = running && cpu_req && !cpu_we && hit;
   assign st_ack     = running && cpu_req && cpu_we && !wb_full;
   assign miss_start = running && cpu_req && !cpu_we && !hit;
   assign cpu_ack    = ld_ack || st_ack;
   assign cpu_rdata  = ld_ack ? ld_data : '0;
   assign wb_push    = st_ack;

   // array write: refill or store-hit merge (never both: stores wait in MISS)
   assign arr_fill    = busy_q && rd_q && mem_ack;
   assign arr_wr_en   = arr_fill || (st_ack && hit);
   assign arr_wr_idx  = arr_fill ? miss_waddr_q[IDX_W-1:0] : req_idx;
   assign arr_wr_be   = arr_fill ? {NB{1'b1}} : st_be;
   assign arr_wr_data = arr_fill ? mem_rdata : st_lanes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_RUN;
         miss_waddr_q <= '0;
      end else begin
         case (st_q)
            ST_RUN: begin
               if (miss_start) begin
                  st_q         <= ST_MISS;
                  miss_waddr_q <= req_waddr;
               end
            end
            ST_MISS: begin
               if (arr_fill) begin
                  st_q <= ST_RUN;
               end
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   // memory side: one transfer at a time, hazard-free refill first
   assign grant_rd = !busy_q && (st_q == ST_MISS) && !wb_hazard;
   assign grant_wr = !busy_q && !grant_rd && !wb_empty;
   assign wb_pop   = busy_q && !rd_q && mem_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
      end else if (busy_q) begin
         if (mem_ack) begin
            busy_q <= 1'b0;
         end
      end else if (grant_rd || grant_wr) begin
         busy_q <= 1'b1;
         rd_q   <= grant_rd;
      end
   end

   assign mem_req   = busy_q;
   assign mem_we    = busy_q && !rd_q;
   assign mem_addr  = {(rd_q ? miss_waddr_q : wb_head_waddr), {OFF_W{1'b0}}};
   assign mem_be    = rd_q ? {NB{1'b1}} : wb_head_be;
   assign mem_wdata = wb_head_data;

   AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MISS) |-> !cpu_ack)                                   // R3
      else $error("core acknowledged during a miss");

   AST_READ_ONLY_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (st_q == ST_MISS))                       // R3
      else $error("memory read outside a miss");

   AST_READ_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !wb_hazard)                              // R8
      else $error("refill overtook a matching buffered store");

   AST_FULL_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && wb_full) |-> !cpu_ack)                      // R4
      else $error("store accepted with a full buffer");

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_be) && $stable(mem_wdata)))  // R10
      else $error("memory request changed before acknowledge");

endmodule

// File: tb/wt_dcache_test.sv
`timescale 1ns/1ps
module wt_dcache_test;

   typedef struct packed {
      logic        we;
      logic [1:0]  sz;
      logic        sx;
      logic [31:0] addr;
      logic [31:0] data;
   } op_t;

   localparam int NOPS = 16;
   localparam op_t OPS [NOPS] = '{
      '{1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0},
      '{1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0},
      '{1'b1, 2'd0, 1'b0, 32'h0000_0101, 32'h0000_00AB},
      '{1'b0, 2'd0, 1'b1, 32'h0000_0101, 32'h0},
      '{1'b0, 2'd1, 1'b0, 32'h0000_0102, 32'h0},
      '{1'b1, 2'd1, 1'b0, 32'h0000_0102, 32'h0000_8001},
      '{1'b0, 2'd1, 1'b1, 32'h0000_0102, 32'h0},
      '{1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0},
      '{1'b0, 2'd2, 1'b0, 32'h0000_0500, 32'h0},
      '{1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0},
      '{1'b1, 2'd2, 1'b0, 32'h0000_2008, 32'h1234_5678},
      '{1'b0, 2'd2, 1'b0, 32'h0000_2008, 32'h0},
      '{1'b0, 2'd0, 1'b0, 32'h0000_200B, 32'h0},
      '{1'b1, 2'd0, 1'b0, 32'h0000_200A, 32'h0000_007F},
      '{1'b0, 2'd1, 1'b1, 32'h0000_200A, 32'h0},
      '{1'b0, 2'd2, 1'b0, 32'hFFFF_FFFC, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_req, cpu_we, cpu_sext;
   logic [1:0]  cpu_size;
   logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
   logic        cpu_ack;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;

   int n_chk = 0;
   int n_fail = 0;
   int lat = 2;
   int lat_cnt = 0;
   int n_rd = 0;
   int n_wr = 0;
   bit prev_pend = 0;
   logic [31:0] prev_addr;
   logic prev_we;

   bit [31:0] mem_m [bit [29:0]];
   bit [31:0] ref_m [bit [29:0]];
   bit [29:0] wlog [$];
   bit [29:0] slog [$];
   bit        bv [256];
   bit [21:0] bt [256];

   always #2 clk = ~clk;

   wt_dcache uut (
      .clk (clk), .rst_n (rst_n),
      .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_size (cpu_size), .cpu_sext (cpu_sext),
      .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cpu_ack (cpu_ack), .cpu_rdata (cpu_rdata),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_be (mem_be),
      .mem_ack (mem_ack), .mem_rdata (mem_rdata), .mem_wdata (mem_wdata)
   );

   function automatic bit [31:0] seed_word(bit [29:0] wa);
      return {wa[15:0], wa[13:0], 2'b01} ^ 32'h9E37_79B9;
   endfunction

   function automatic bit [31:0] mem_word(bit [29:0] wa);
      return mem_m.exists(wa) ? mem_m[wa] : seed_word(wa);
   endfunction

   function automatic bit [31:0] ref_word(bit [29:0] wa);
      return ref_m.exists(wa) ? ref_m[wa] : seed_word(wa);
   endfunction

   // expected load result per R9
   function automatic bit [31:0] expect_load(bit [31:0] w, bit [1:0] sz, bit sx, bit [1:0] lo);
      bit [7:0]  b;
      bit [15:0] h;
      b = w[8*lo +: 8];
      h = lo[1] ? w[31:16] : w[15:0];
      if (sz == 2'd0) return sx ? {{24{b[7]}}, b} : {24'd0, b};
      if (sz == 2'd1) return sx ? {{16{h[15]}}, h} : {16'd0, h};
      return w;
   endfunction

   function automatic bit [31:0] merge_store(bit [31:0] w, bit [1:0] sz, bit [1:0] lo, bit [31:0] d);
      bit [31:0] r;
      r = w;
      if (sz == 2'd0) r[8*lo +: 8] = d[7:0];
      else if (sz == 2'd1) begin
         if (lo[1]) r[31:16] = d[15:0];
         else r[15:0] = d[15:0];
      end else r = d;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory model: ack raised at a falling edge after lat waiting edges
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat_cnt = 0;
         prev_pend = 0;
      end else begin
         if (prev_pend && mem_req)
            check(mem_addr == prev_addr && mem_we == prev_we, "R10 request held", mem_addr, prev_addr);
         prev_pend = 0;
         if (mem_ack) mem_ack <= 1'b0;
         else if (mem_req) begin
            if (lat_cnt >= lat) begin
               mem_ack <= 1'b1;
               lat_cnt = 0;
               if (mem_we) begin
                  bit [31:0] w;
                  w = mem_word(mem_addr[31:2]);
                  for (int b = 0; b < 4; b++)
                     if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
                  mem_m[mem_addr[31:2]] = w;
                  n_wr++;
                  wlog.push_back(mem_addr[31:2]);
               end else begin
                  check(mem_be == 4'hF && mem_addr[1:0] == 2'b00, "R3 read form", {28'd0, mem_be}, 32'hF);
                  mem_rdata <= mem_word(mem_addr[31:2]);
                  n_rd++;
               end
            end else begin
               lat_cnt++;
               prev_pend = 1;
               prev_addr = mem_addr;
               prev_we = mem_we;
            end
         end
      end
   end

   // drives one access, returns data and the number of waited edges
   task automatic do_op(input op_t op, output logic [31:0] rd, output int waits);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = op.we; cpu_size = op.sz; cpu_sext = op.sx;
      cpu_addr = op.addr; cpu_wdata = op.data;
      waits = 0;
      forever begin
         #1;
         if (cpu_ack) break;
         @(negedge clk);
         waits++;
         if (waits > 5000) begin
            check(1'b0, "watchdog access", 32'd0, 32'd1);
            break;
         end
      end
      rd = cpu_rdata;
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      cpu_req = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // one access checked against the bench's own cache and memory model
   task automatic run_op(input op_t op);
      logic [31:0] rd;
      int waits, rd0;
      bit [7:0] idx;
      bit exp_hit;
      idx = op.addr[9:2];
      exp_hit = bv[idx] && bt[idx] == op.addr[31:10];
      rd0 = n_rd;
      do_op(op, rd, waits);
      if (op.we) begin
         check(waits == 0, "R4 store accepted at once", waits, 0);
         ref_m[op.addr[31:2]] = merge_store(ref_word(op.addr[31:2]), op.sz, op.addr[1:0], op.data);
         slog.push_back(op.addr[31:2]);
      end else begin
         check((waits == 0) == exp_hit, exp_hit ? "R2 R11 hit expected" : "R3 R6 R11 miss expected",
               waits, exp_hit ? 0 : 1);
         check(n_rd - rd0 == (exp_hit ? 0 : 1), "R2 R3 memory reads", n_rd - rd0, exp_hit ? 0 : 1);
         check(rd == expect_load(ref_word(op.addr[31:2]), op.sz, op.sx, op.addr[1:0]),
               "R9 R8 load data", rd, expect_load(ref_word(op.addr[31:2]), op.sz, op.sx, op.addr[1:0]));
         bv[idx] = 1'b1;
         bt[idx] = op.addr[31:10];
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) bv[i] = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog run", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int waits, wr0;
      op_t op;
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'd2; cpu_sext = 1'b0;
      cpu_addr = '0; cpu_wdata = '0; mem_ack = 1'b0; mem_rdata = '0;
      for (int i = 0; i < 256; i++) bv[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(mem_req == 1'b0, "R1 no request after reset", mem_req, 0);
      check(cpu_ack == 1'b0, "R1 no ack when idle", cpu_ack, 0);

      // table walk
      for (int k = 0; k < NOPS; k++) begin
         run_op(OPS[k]);
         idle(1);
      end
      idle(200);
      for (int k = 0; k < slog.size(); k++)
         check(mem_word(slog[k]) == ref_word(slog[k]), "R5 memory matches", mem_word(slog[k]), ref_word(slog[k]));

      // buffer full and drain order, slow memory
      lat = 30;
      wlog.delete(); slog.delete();
      for (int k = 0; k < 5; k++) begin
         op.we = 1'b1; op.sx = 1'b0;
         op.sz = (k == 1) ? 2'd0 : (k == 2) ? 2'd1 : 2'd2;
         op.addr = 32'h0000_6000 + 32'(4 * k) + ((k == 1) ? 32'd1 : (k == 2) ? 32'd2 : 32'd0);
         op.data = 32'hC0DE_0000 + 32'(k * 32'h1111) + ((k == 1) ? 32'hC3 : 32'd0);
         @(negedge clk);
         cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = op.sz; cpu_sext = 1'b0;
         cpu_addr = op.addr; cpu_wdata = op.data;
         #1;
         if (k < 4) check(cpu_ack == 1'b1, "R4 store accepted below depth", cpu_ack, 1);
         else begin
            check(cpu_ack == 1'b0, "R4 store held when full", cpu_ack, 0);
            waits = 0;
            while (!cpu_ack && waits < 5000) begin
               @(negedge clk); #1; waits++;
            end
            check(cpu_ack == 1'b1, "R4 held store later accepted", cpu_ack, 1);
         end
         ref_m[op.addr[31:2]] = merge_store(ref_word(op.addr[31:2]), op.sz, op.addr[1:0], op.data);
         slog.push_back(op.addr[31:2]);
      end
      idle(250);
      check(wlog.size() == slog.size(), "R7 one write per store", wlog.size(), slog.size());
      for (int k = 0; k < slog.size() && k < wlog.size(); k++)
         check(wlog[k] == slog[k], "R7 drain order", {2'b0, wlog[k]}, {2'b0, slog[k]});
      for (int k = 0; k < slog.size(); k++)
         check(mem_word(slog[k]) == ref_word(slog[k]), "R5 lanes and enables", mem_word(slog[k]), ref_word(slog[k]));

      // load right behind a slow store to the same word
      lat = 12;
      op = '{1'b1, 2'd2, 1'b0, 32'h0000_3000, 32'hCAFE_F00D};
      run_op(op);
      op = '{1'b0, 2'd2, 1'b0, 32'h0000_3000, 32'h0};
      run_op(op);
      idle(100);

      // reset discards a pending store and all valid bits
      lat = 30;
      wr0 = n_wr;
      op = '{1'b1, 2'd2, 1'b0, 32'h0000_7000, 32'h5555_AAAA};
      do_op(op, rd, waits);
      @(negedge clk); cpu_req = 1'b0;
      do_reset();
      ref_m[30'h0000_1C00] = mem_word(30'h0000_1C00);
      #1;
      check(mem_req == 1'b0, "R1 request dropped by reset", mem_req, 0);
      idle(150);
      check(n_wr == wr0, "R1 buffer emptied", n_wr, wr0);
      rd = '0;
      op = '{1'b0, 2'd2, 1'b0, 32'h0000_0100, 32'h0};
      run_op(op);
      op = '{1'b0, 2'd2, 1'b0, 32'h0000_7000, 32'h0};
      run_op(op);
      idle(5);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule